// File: doc/BRIEF.md
# Lockable Timer and Watchdog Settings Bank

This block holds the settings of a timer and watchdog subsystem: a configuration byte, a clock prescaler selector, a 16-bit timer reload word, a watchdog count byte and a timer control byte. A CPU-style bus reaches all of them. The bus has one address, separate write and read strobes, a write data word and a read data word. The stored values drive the timer and watchdog logic through dedicated output ports. That logic sits outside this block.

Software protects each setting with a sticky lock bit held in the low nibble of the configuration byte. A lock bit can be set by writing 1 and is cleared only by reset. A locked target ignores writes. A read of a locked target returns a fixed filler pattern in place of its contents. The reload-word lock also guards the timer control byte.

Reads are served by a small sequencer with four states. RD_IDLE drives zero on the read bus. RD_OPEN drives the contents of the target. RD_MASK drives the filler pattern. RD_VOID drives zero for an unmapped address. A cycle with the read strobe low leads to RD_IDLE. A read strobe to an unmapped address leads to RD_VOID. A read strobe to a locked target leads to RD_MASK. A read strobe to an unlocked target leads to RD_OPEN. Every state takes this same decision again on the next edge, so each state lasts exactly one cycle unless a new read strobe arrives.

Top module: `twc_lock_bank`

## Requirements
- R1: After reset, the following values hold: configuration byte 00h, prescaler 0, reload word FFFFh, watchdog count 00h, control byte 00h, read bus 0000h.
- R2: The address map is: 0 configuration, 1 prescaler, 2 reload word, 3 watchdog count, 4 control byte. A read strobe in cycle N presents its data on `bus_rdata` during cycle N+1. In any cycle not preceded by a read strobe, `bus_rdata` is 0000h. A read of address 5, 6 or 7 returns 0000h.
- R3: The configuration byte has this layout. Bit 0 locks the configuration byte. Bit 1 locks the prescaler. Bit 2 locks the reload word and the control byte. Bit 3 locks the watchdog count. Bit 4 drives `wd_clk_sel`. Bit 5 drives `wd_match_mode`. Bits 7:6 always read 0.
- R4: Writing 0 to a lock bit leaves it set. Only reset clears a lock bit.
- R5: While bit 0 is set, every write to the configuration byte is ignored, including its mode bits.
- R6: The prescaler stores `bus_wdata[2:0]` and reads back with bits 15:3 at 0. Its writes are ignored while bit 1 is set.
- R7: Writes to the reload word and to the control byte are ignored while bit 2 is set.
- R8: Writes to the watchdog count are ignored while bit 3 is set.
- R9: A read of a locked target returns A5A5h for the reload word and 00A5h for the byte targets. The lock state used is the one in force in the cycle of the read strobe.
- R10: A write of 0000h to the reload word is ignored. Any write of 0001h through FFFFh is accepted when the word is unlocked.
- R11: A write to address 5, 6 or 7 changes no setting.
- R12: The byte targets ignore `bus_wdata[15:8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Target address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle after the read strobe |
| wd_clk_sel | output | 1 | Watchdog clock source select |
| wd_match_mode | output | 1 | Watchdog serviced by data match when 1 |
| prescale_sel | output | 3 | Prescaler divide selector |
| t0_preset | output | 16 | Timer reload word |
| wd_count | output | 8 | Watchdog count setting |
| t0_ctrl | output | 8 | Timer control byte |

## Verification
A lock bit lost or set in error shows at the ports at the next write attempt to its target. It also shows on the next read of that target, which returns either the filler pattern or the real contents when the other was due, one cycle after the read strobe. The bench sweeps all 64 combinations of the six configuration bits, each combination after its own reset. For each combination it attempts writes to every address, then checks every output port and every read-back word against values derived from the lock pattern. A read sequencer stuck outside RD_IDLE shows as nonzero read data in the cycle that follows a read.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam int ADR_W = 3;

    localparam logic [ADR_W-1:0] ADR_CFG    = 3'd0;
    localparam logic [ADR_W-1:0] ADR_PSC    = 3'd1;
    localparam logic [ADR_W-1:0] ADR_PRESET = 3'd2;
    localparam logic [ADR_W-1:0] ADR_WDCNT  = 3'd3;
    localparam logic [ADR_W-1:0] ADR_TCTL   = 3'd4;

    localparam int LK_CFG   = 0;
    localparam int LK_PSC   = 1;
    localparam int LK_PRE   = 2;
    localparam int LK_WDC   = 3;
    localparam int LOCK_N   = 4;
    localparam int CF_WDCLK = 4;
    localparam int CF_MATCH = 5;
    localparam int CFG_W    = 6;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_OPEN,
        RD_MASK,
        RD_VOID
    } rd_state_e;
endpackage

// File: rtl/twc_cfg_reg.sv
module twc_cfg_reg
    import twc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CFG_W-1:0]  wdata,
    output logic [BYTE_W-1:0] cfg_q
);
    logic [BYTE_W-1:0] cfg_d;

    // lock bits only accumulate; mode bits follow the write; reserved stay 0
    always_comb begin
        cfg_d = '0;
        cfg_d[LOCK_N-1:0] = cfg_q[LOCK_N-1:0] | wdata[LOCK_N-1:0];
        cfg_d[CF_WDCLK]   = wdata[CF_WDCLK];
        cfg_d[CF_MATCH]   = wdata[CF_MATCH];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_hit && !cfg_q[LK_CFG]) begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/twc_data_reg.sv
module twc_data_reg #(
    parameter int           W           = 8,
    parameter logic [W-1:0] INIT        = '0,
    parameter bit           REJECT_ZERO = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic         locked,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic accept;

    generate
        if (REJECT_ZERO) begin : g_nonzero
            assign accept = wr_hit && !locked && (wdata != '0);
        end else begin : g_any
            assign accept = wr_hit && !locked;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (accept) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/twc_read_fsm.sv
module twc_read_fsm
    import twc_pkg::*;
#(
    parameter int         DATA_W    = 16,
    parameter logic [7:0] MASK_BYTE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADR_W-1:0]  addr,
    input  logic              tgt_locked,
    input  logic              tgt_mapped,
    input  logic              is_word,
    input  logic [DATA_W-1:0] open_data,
    output logic [ADR_W-1:0]  addr_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int              REPS        = DATA_W / 8;
    localparam logic [DATA_W-1:0] MASK_WIDE   = {REPS{MASK_BYTE}};
    localparam logic [DATA_W-1:0] MASK_NARROW = {{(DATA_W-8){1'b0}}, MASK_BYTE};

    rd_state_e state_q, state_d;

    always_comb begin
        state_d = RD_IDLE;
        if (rd_req) begin
            if (!tgt_mapped) begin
                state_d = RD_VOID;
            end else if (tgt_locked) begin
                state_d = RD_MASK;
            end else begin
                state_d = RD_OPEN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (rd_req) begin
            addr_q <= addr;
        end
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE: rdata = '0;
            RD_OPEN: rdata = open_data;
            RD_MASK: rdata = is_word ? MASK_WIDE : MASK_NARROW;
            RD_VOID: rdata = '0;
        endcase
    end
endmodule

// File: rtl/twc_lock_bank.sv
module twc_lock_bank
    import twc_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                BYTE_W      = 8,
    parameter int                PSC_W       = 3,
    parameter logic [DATA_W-1:0] PRESET_INIT = 16'hFFFF,
    parameter logic [7:0]        MASK_BYTE   = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADR_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_clk_sel,
    output logic              wd_match_mode,
    output logic [PSC_W-1:0]  prescale_sel,
    output logic [DATA_W-1:0] t0_preset,
    output logic [BYTE_W-1:0] wd_count,
    output logic [BYTE_W-1:0] t0_ctrl
);
    localparam int BYTE_PAD = DATA_W - BYTE_W;
    localparam int PSC_PAD  = DATA_W - PSC_W;

    logic [BYTE_W-1:0] cfg_q;
    logic              tgt_locked, tgt_mapped, is_word;
    logic [ADR_W-1:0]  rd_addr_q;
    logic [DATA_W-1:0] open_data;

    twc_cfg_reg #(.BYTE_W(BYTE_W)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(bus_wr && bus_addr == ADR_CFG),
        .wdata (bus_wdata[CFG_W-1:0]),
        .cfg_q (cfg_q)
    );

    twc_data_reg #(.W(PSC_W), .INIT('0), .REJECT_ZERO(1'b0)) i_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(bus_wr && bus_addr == ADR_PSC),
        .locked(cfg_q[LK_PSC]),
        .wdata (bus_wdata[PSC_W-1:0]),
        .q     (prescale_sel)
    );

    twc_data_reg #(.W(DATA_W), .INIT(PRESET_INIT), .REJECT_ZERO(1'b1)) i_preset (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(bus_wr && bus_addr == ADR_PRESET),
        .locked(cfg_q[LK_PRE]),
        .wdata (bus_wdata),
        .q     (t0_preset)
    );

    twc_data_reg #(.W(BYTE_W), .INIT('0), .REJECT_ZERO(1'b0)) i_wdcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(bus_wr && bus_addr == ADR_WDCNT),
        .locked(cfg_q[LK_WDC]),
        .wdata (bus_wdata[BYTE_W-1:0]),
        .q     (wd_count)
    );

    // control byte shares the reload-word lock
    twc_data_reg #(.W(BYTE_W), .INIT('0), .REJECT_ZERO(1'b0)) i_tctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(bus_wr && bus_addr == ADR_TCTL),
        .locked(cfg_q[LK_PRE]),
        .wdata (bus_wdata[BYTE_W-1:0]),
        .q     (t0_ctrl)
    );

    always_comb begin
        tgt_mapped = 1'b1;
        unique case (bus_addr)
            ADR_CFG:              tgt_locked = cfg_q[LK_CFG];
            ADR_PSC:              tgt_locked = cfg_q[LK_PSC];
            ADR_PRESET, ADR_TCTL: tgt_locked = cfg_q[LK_PRE];
            ADR_WDCNT:            tgt_locked = cfg_q[LK_WDC];
            default: begin
                tgt_locked = 1'b0;
                tgt_mapped = 1'b0;
            end
        endcase
    end

    always_comb begin
        is_word = (rd_addr_q == ADR_PRESET);
        unique case (rd_addr_q)
            ADR_CFG:    open_data = {{BYTE_PAD{1'b0}}, cfg_q};
            ADR_PSC:    open_data = {{PSC_PAD{1'b0}}, prescale_sel};
            ADR_PRESET: open_data = t0_preset;
            ADR_WDCNT:  open_data = {{BYTE_PAD{1'b0}}, wd_count};
            ADR_TCTL:   open_data = {{BYTE_PAD{1'b0}}, t0_ctrl};
            default:    open_data = '0;
        endcase
    end

    twc_read_fsm #(.DATA_W(DATA_W), .MASK_BYTE(MASK_BYTE)) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (bus_rd),
        .addr      (bus_addr),
        .tgt_locked(tgt_locked),
        .tgt_mapped(tgt_mapped),
        .is_word   (is_word),
        .open_data (open_data),
        .addr_q    (rd_addr_q),
        .rdata     (bus_rdata)
    );

    assign wd_clk_sel    = cfg_q[CF_WDCLK];
    assign wd_match_mode = cfg_q[CF_MATCH];
endmodule

// File: rtl/twc_checker.sv
module twc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic        bus_rd,
    input logic [15:0] bus_rdata,
    input logic [7:0]  cfg_q,
    input logic [15:0] t0_preset
);
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 16'h0000)); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7:6] == 2'b00); // R3

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cfg_q[3:0]) & ~cfg_q[3:0]) == 4'b0000)); // R4

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[0] |=> $stable(cfg_q)); // R5

    AST_PRESET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[2] |=> $stable(t0_preset)); // R7

    AST_PRESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd2 && cfg_q[2]) |=> (bus_rdata == 16'hA5A5)); // R9

    AST_PRESET_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        t0_preset != 16'h0000); // R10
endmodule

bind twc_lock_bank twc_checker i_twc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .cfg_q    (cfg_q),
    .t0_preset(t0_preset)
);

// File: tb/test_twc_lock_bank.sv
module test_twc_lock_bank;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wd_clk_sel, wd_match_mode;
    logic [2:0]  prescale_sel;
    logic [15:0] t0_preset;
    logic [7:0]  wd_count, t0_ctrl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    twc_lock_bank i_twc_lock_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_clk_sel(wd_clk_sel), .wd_match_mode(wd_match_mode),
        .prescale_sel(prescale_sel), .t0_preset(t0_preset),
        .wd_count(wd_count), .t0_ctrl(t0_ctrl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // expected settings model
    logic [7:0]  e_cfg, e_wdc, e_tctl;
    logic [2:0]  e_psc;
    logic [15:0] e_pre;

    function automatic logic [15:0] read_exp(input logic [2:0] a);
        unique case (a)
            3'd0:    return e_cfg[0] ? 16'h00A5 : {8'h00, e_cfg};
            3'd1:    return e_cfg[1] ? 16'h00A5 : {13'h0, e_psc};
            3'd2:    return e_cfg[2] ? 16'hA5A5 : e_pre;
            3'd3:    return e_cfg[3] ? 16'h00A5 : {8'h00, e_wdc};
            3'd4:    return e_cfg[2] ? 16'h00A5 : {8'h00, e_tctl};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string read_req(input logic [2:0] a);
        if (a > 3'd4) return "R2";
        if (a == 3'd0 ? e_cfg[0] : a == 3'd1 ? e_cfg[1] : a == 3'd3 ? e_cfg[3] : e_cfg[2])
            return "R9";
        return "R2";
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                errors++;
                checks++;
                $display("FAIL R1 watchdog: actual timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] rd;
        for (int m = 0; m < 64; m++) begin
            @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R1 reset state
            check("R1", "reset cfg mode", {14'h0, wd_match_mode, wd_clk_sel}, 16'h0);
            check("R1", "reset prescale", {13'h0, prescale_sel}, 16'h0);
            check("R1", "reset preset", t0_preset, 16'hFFFF);
            check("R1", "reset wdcount", {8'h0, wd_count}, 16'h0);
            check("R1", "reset ctrl", {8'h0, t0_ctrl}, 16'h0);
            check("R1", "reset rdata", bus_rdata, 16'h0);

            e_psc = '0; e_pre = 16'hFFFF; e_wdc = '0; e_tctl = '0;

            // R3 R12: reserved and upper bits dropped
            bus_write(3'd0, 16'hFFC0 | 16'(m));
            e_cfg = 8'(m);
            // R4 R5: attempt to clear everything
            bus_write(3'd0, 16'h0000);
            if (!e_cfg[0]) e_cfg = e_cfg & 8'h0F;
            check(e_cfg[0] ? "R5" : "R4", "cfg mode bits",
                  {14'h0, wd_match_mode, wd_clk_sel}, {14'h0, e_cfg[5:4]});

            // R6 prescaler, upper bits ignored
            bus_write(3'd1, 16'hFFFF);
            if (!e_cfg[1]) e_psc = 3'b111;
            check("R6", "prescale", {13'h0, prescale_sel}, {13'h0, e_psc});

            // R10 zero write ignored, R7 lock
            bus_write(3'd2, 16'h0000);
            check("R10", "preset after zero write", t0_preset, e_pre);
            bus_write(3'd2, 16'h1200 | 16'(m));
            if (!e_cfg[2]) e_pre = 16'h1200 | 16'(m);
            check("R7", "preset", t0_preset, e_pre);

            // R8 R12
            bus_write(3'd3, 16'hAB40 | 16'(m));
            if (!e_cfg[3]) e_wdc = 8'h40 | 8'(m);
            check("R8", "wdcount", {8'h0, wd_count}, {8'h0, e_wdc});

            // R7 control byte shares reload lock
            bus_write(3'd4, 16'h773C);
            if (!e_cfg[2]) e_tctl = 8'h3C;
            check("R7", "ctrl", {8'h0, t0_ctrl}, {8'h0, e_tctl});

            // R11 unmapped writes
            for (int a = 5; a < 8; a++) bus_write(3'(a), 16'hFFFF);
            check("R11", "cfg mode after unmapped", {14'h0, wd_match_mode, wd_clk_sel}, {14'h0, e_cfg[5:4]});
            check("R11", "prescale after unmapped", {13'h0, prescale_sel}, {13'h0, e_psc});
            check("R11", "preset after unmapped", t0_preset, e_pre);
            check("R11", "wdcount after unmapped", {8'h0, wd_count}, {8'h0, e_wdc});
            check("R11", "ctrl after unmapped", {8'h0, t0_ctrl}, {8'h0, e_tctl});

            // R2 R9 read-back of every address
            for (int a = 0; a < 8; a++) begin
                bus_read(3'(a), rd);
                check(read_req(3'(a)), $sformatf("read addr %0d", a), rd, read_exp(3'(a)));
                @(negedge clk);
                check("R2", "rdata idle after read", bus_rdata, 16'h0000);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule